// File: doc/BRIEF.md
# Four-Lane Link Signature Checker

This block sits behind a multi-lane serial link receiver that delivers four 16-bit words per user clock, qualified by a single valid strobe. During link bring-up the transmitter drives a fixed test signature: two lanes carry fixed patterns, one lane counts upward and one lane counts downward. The checker compares every received word against that signature. It raises a per-lane error pulse for any mismatch. It sorts ramp discontinuities into skipped words and repeated words and keeps a saturating count of each. It shows whether it is locked onto the ramps.

Cycles with valid low are gaps, for example while the receiver realigns, and they never count as errors. The first valid word after reset, or after a jump too large to be a skip, only seeds the expected ramp values. A separate latency meter starts on a marker pulse from the transmit side, which carries the up-ramp value just sent. It stops when that value comes back on the up-ramp lane, so the round-trip delay of the link can be read in user clocks.

Top module: `lane_pattern_checker`

## Requirements
- R1: After reset, err_flags, missing_cnt, extra_cnt, lat_cycles, lat_done and locked are all zero.
- R2: The first valid word while unlocked is never flagged and only seeds the ramps. locked is high from the next clock on.
- R3: For a valid word while locked, err_flags[0] pulses high in the next clock if lane0 is not 0xAAAA, and err_flags[2] does so if lane2 is not 0xCCCC. Bit i of err_flags belongs to lane i.
- R4: While locked, lane1 must equal the previous valid lane1 word plus one and lane3 the previous valid lane3 word minus one, both modulo 2^16 (0xFFFF to 0x0000 is correct). Any other value sets err_flags[1] or err_flags[3] in the next clock.
- R5: A ramp step of 2 to MAX_SKIP (default 8) adds step-1 to missing_cnt. Both ramp lanes add to it. The following word is expected relative to the received value.
- R6: A repeated ramp word (step 0) adds one to extra_cnt for each ramp lane that repeats.
- R7: A ramp step above MAX_SKIP is flagged, changes no counter and drops locked. The next valid word reseeds and is not checked.
- R8: A cycle with valid low changes no counter and no expected value, and err_flags reads zero in the following clock.
- R9: missing_cnt and extra_cnt are CNT_W bits wide (default 32) and stop at 2^CNT_W-1 without wrapping.
- R10: A clear pulse zeroes both counters in the next clock and wins over an increment in the same clock.
- R11: When marker is high, marker_value is captured. lat_cycles then becomes the number of clocks from that edge to the first edge with valid high and lane1 equal to the captured value, and lat_done rises. A loop of 134 clocks is measured exactly.
- R12: lat_cycles and lat_done hold until the next marker. A marker drops lat_done in the next clock and restarts the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of both counters |
| valid | input | 1 | Qualifies the four lane words |
| lane0 | input | 16 | Fixed-pattern lane, expected 0xAAAA |
| lane1 | input | 16 | Up-ramp lane |
| lane2 | input | 16 | Fixed-pattern lane, expected 0xCCCC |
| lane3 | input | 16 | Down-ramp lane |
| marker | input | 1 | Transmit-side latency start pulse |
| marker_value | input | 16 | Up-ramp value sent with the marker |
| err_flags | output | 4 | Per-lane error pulse, bit i for lane i |
| missing_cnt | output | CNT_W | Saturating count of skipped ramp words |
| extra_cnt | output | CNT_W | Saturating count of repeated ramp words |
| locked | output | 1 | Ramps seeded and tracking |
| lat_cycles | output | LAT_W | Last measured latency in clocks |
| lat_done | output | 1 | A latency result is held |

## Verification
Several properties are checked on every clock: seeding always leads to lock, no error pulse follows an unlocked or idle cycle, ramp history stays frozen across gaps, counters never fall except on clear, and the latency result is stable while no marker arrives. Only the directed scenarios can show that the error classification is correct. These cover the exact increments for skips of various sizes on each ramp lane, repeats, the wrap at 0xFFFF, reseeding after a wild jump, saturation at the counter limit, and the latency values measured with and without gaps in valid.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    typedef enum logic [1:0] {
        RC_OK    = 2'd0,
        RC_EXTRA = 2'd1,
        RC_MISS  = 2'd2,
        RC_WILD  = 2'd3
    } ramp_cls_e;
endpackage

// File: rtl/lpc_ramp_track.sv
module lpc_ramp_track
    import lpc_pkg::*;
#(
    parameter int W        = 16,
    parameter int MAX_SKIP = 8,
    parameter bit DOWN     = 1'b0,
    parameter int MW       = $clog2(MAX_SKIP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [W-1:0]  word,
    output ramp_cls_e     cls,
    output logic [MW-1:0] miss_n
);
    typedef struct packed {
        logic [W-1:0] last;
    } trk_t;

    trk_t         r_d, r_q;
    logic [W-1:0] delta;

    generate
        if (DOWN) begin : g_down
            assign delta = r_q.last - word;
        end else begin : g_up
            assign delta = word - r_q.last;
        end
    endgenerate

    always_comb begin
        r_d    = r_q;
        cls    = RC_WILD;
        miss_n = '0;
        if (delta == W'(1)) begin
            cls = RC_OK;
        end else if (delta == '0) begin
            cls = RC_EXTRA;
        end else if (delta <= W'(MAX_SKIP)) begin
            cls    = RC_MISS;
            miss_n = MW'(delta - W'(1));
        end
        if (valid) begin
            r_d.last = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_LAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(r_q.last)); // R8
endmodule

// File: rtl/lpc_sat_acc.sv
module lpc_sat_acc #(
    parameter int CNT_W = 32,
    parameter int IW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [IW-1:0]    inc,
    output logic [CNT_W-1:0] acc
);
    localparam int SW = ((CNT_W > IW) ? CNT_W : IW) + 1;
    localparam logic [SW-1:0] LIMIT = SW'({CNT_W{1'b1}});

    typedef struct packed {
        logic [CNT_W-1:0] acc;
    } acc_t;

    acc_t          r_d, r_q;
    logic [SW-1:0] sum;

    always_comb begin
        r_d = r_q;
        sum = SW'(r_q.acc) + SW'(inc);
        if (clear) begin
            r_d.acc = '0;
        end else if (sum > LIMIT) begin
            r_d.acc = {CNT_W{1'b1}};
        end else begin
            r_d.acc = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign acc = r_q.acc;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> r_q.acc >= $past(r_q.acc)); // R9
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> r_q.acc == '0); // R10
endmodule

// File: rtl/lpc_latency.sv
module lpc_latency #(
    parameter int W     = 16,
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             marker,
    input  logic [W-1:0]     marker_value,
    input  logic             valid,
    input  logic [W-1:0]     word,
    output logic [LAT_W-1:0] lat,
    output logic             done
);
    typedef struct packed {
        logic             run;
        logic             done;
        logic [W-1:0]     tgt;
        logic [LAT_W-1:0] cnt;
        logic [LAT_W-1:0] lat;
    } lat_t;

    lat_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (marker) begin
            r_d.run  = 1'b1;
            r_d.done = 1'b0;
            r_d.tgt  = marker_value;
            r_d.cnt  = LAT_W'(1);
        end else if (r_q.run) begin
            if (valid && word == r_q.tgt) begin
                r_d.run  = 1'b0;
                r_d.done = 1'b1;
                r_d.lat  = r_q.cnt;
            end else if (r_q.cnt != {LAT_W{1'b1}}) begin
                r_d.cnt = r_q.cnt + LAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lat  = r_q.lat;
    assign done = r_q.done;

    AST_MARKER_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        marker |=> !r_q.done); // R12
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!marker && r_q.done) |=> ($stable(r_q.lat) && r_q.done)); // R12
endmodule

// File: rtl/lane_pattern_checker.sv
module lane_pattern_checker
    import lpc_pkg::*;
#(
    parameter int              W        = 16,
    parameter int              CNT_W    = 32,
    parameter int              LAT_W    = 16,
    parameter int              MAX_SKIP = 8,
    parameter logic [W-1:0]    PAT_A    = 16'hAAAA,
    parameter logic [W-1:0]    PAT_B    = 16'hCCCC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             valid,
    input  logic [W-1:0]     lane0,
    input  logic [W-1:0]     lane1,
    input  logic [W-1:0]     lane2,
    input  logic [W-1:0]     lane3,
    input  logic             marker,
    input  logic [W-1:0]     marker_value,
    output logic [3:0]       err_flags,
    output logic [CNT_W-1:0] missing_cnt,
    output logic [CNT_W-1:0] extra_cnt,
    output logic             locked,
    output logic [LAT_W-1:0] lat_cycles,
    output logic             lat_done
);
    localparam int MW = $clog2(MAX_SKIP + 1);
    localparam int IW = MW + 1;

    typedef struct packed {
        logic       locked;
        logic [3:0] err;
    } top_t;

    top_t          r_d, r_q;
    ramp_cls_e     cls_up, cls_dn;
    logic [MW-1:0] miss_up, miss_dn;
    logic [IW-1:0] miss_inc, extra_inc;
    logic          chk;

    lpc_ramp_track #(.W(W), .MAX_SKIP(MAX_SKIP), .DOWN(1'b0), .MW(MW)) i_up (
        .clk(clk), .rst_n(rst_n), .valid(valid), .word(lane1),
        .cls(cls_up), .miss_n(miss_up));

    lpc_ramp_track #(.W(W), .MAX_SKIP(MAX_SKIP), .DOWN(1'b1), .MW(MW)) i_dn (
        .clk(clk), .rst_n(rst_n), .valid(valid), .word(lane3),
        .cls(cls_dn), .miss_n(miss_dn));

    always_comb begin
        r_d       = r_q;
        chk       = valid && r_q.locked;
        r_d.err   = '0;
        miss_inc  = '0;
        extra_inc = '0;
        if (chk) begin
            r_d.err[0] = (lane0 != PAT_A);
            r_d.err[1] = (cls_up != RC_OK);
            r_d.err[2] = (lane2 != PAT_B);
            r_d.err[3] = (cls_dn != RC_OK);
            miss_inc   = IW'(miss_up) + IW'(miss_dn);
            extra_inc  = IW'(cls_up == RC_EXTRA) + IW'(cls_dn == RC_EXTRA);
            if (cls_up == RC_WILD || cls_dn == RC_WILD) begin
                r_d.locked = 1'b0;
            end
        end else if (valid) begin
            r_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    lpc_sat_acc #(.CNT_W(CNT_W), .IW(IW)) i_miss (
        .clk(clk), .rst_n(rst_n), .clear(clear), .inc(miss_inc), .acc(missing_cnt));

    lpc_sat_acc #(.CNT_W(CNT_W), .IW(IW)) i_extra (
        .clk(clk), .rst_n(rst_n), .clear(clear), .inc(extra_inc), .acc(extra_cnt));

    lpc_latency #(.W(W), .LAT_W(LAT_W)) i_lat (
        .clk(clk), .rst_n(rst_n), .marker(marker), .marker_value(marker_value),
        .valid(valid), .word(lane1), .lat(lat_cycles), .done(lat_done));

    assign err_flags = r_q.err;
    assign locked    = r_q.locked;

    AST_SEED_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !locked) |=> locked); // R2
    AST_UNLOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> err_flags == 4'b0000); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (err_flags == 4'b0000 && $stable(locked))); // R8
endmodule

// File: tb/test_lane_pattern_checker.sv
module test_lane_pattern_checker;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          valid = 1'b0;
    logic [15:0]   lane0 = '0, lane1 = '0, lane2 = '0, lane3 = '0;
    logic          marker = 1'b0;
    logic [15:0]   marker_value = '0;
    logic [3:0]    err_flags;
    logic [CW-1:0] missing_cnt, extra_cnt;
    logic          locked;
    logic [15:0]   lat_cycles;
    logic          lat_done;

    int errors = 0;
    int checks = 0;
    logic [15:0] u = 16'd100;
    logic [15:0] d = 16'd500;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    lane_pattern_checker #(.CNT_W(CW)) i_lane_pattern_checker (
        .clk(clk), .rst_n(rst_n), .clear(clear), .valid(valid),
        .lane0(lane0), .lane1(lane1), .lane2(lane2), .lane3(lane3),
        .marker(marker), .marker_value(marker_value),
        .err_flags(err_flags), .missing_cnt(missing_cnt), .extra_cnt(extra_cnt),
        .locked(locked), .lat_cycles(lat_cycles), .lat_done(lat_done));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] c, input logic [15:0] e,
                       input logic mk, input logic [15:0] mv, input logic clr);
        valid = v; lane0 = a; lane1 = b; lane2 = c; lane3 = e;
        marker = mk; marker_value = mv; clear = clr;
        @(negedge clk);
        valid = 1'b0; marker = 1'b0; clear = 1'b0;
    endtask

    task automatic good(input logic mk, input logic [15:0] mv);
        cyc(1'b1, 16'hAAAA, u, 16'hCCCC, d, mk, mv, 1'b0);
        u = u + 16'd1;
        d = d - 16'd1;
    endtask

    task automatic t_reset();
        chk("R1 err_flags", 32'(err_flags), 0);
        chk("R1 missing", 32'(missing_cnt), 0);
        chk("R1 extra", 32'(extra_cnt), 0);
        chk("R1 locked", 32'(locked), 0);
        chk("R1 lat", 32'(lat_cycles), 0);
        chk("R1 done", 32'(lat_done), 0);
    endtask

    task automatic t_seed();
        cyc(1'b1, 16'h0000, u, 16'h0000, d, 1'b0, 16'h0, 1'b0);
        u = u + 16'd1; d = d - 16'd1;
        chk("R2 seed no flag", 32'(err_flags), 0);
        chk("R2 locked after seed", 32'(locked), 1);
        for (int i = 0; i < 3; i++) begin
            good(1'b0, 16'h0);
            chk("R4 clean ramps", 32'(err_flags), 0);
        end
    endtask

    task automatic t_const();
        cyc(1'b1, 16'h1234, u, 16'hCCCC, d, 1'b0, 16'h0, 1'b0);
        u = u + 16'd1; d = d - 16'd1;
        chk("R3 lane0 bad", 32'(err_flags), 32'b0001);
        good(1'b0, 16'h0);
        chk("R3 pulse clears", 32'(err_flags), 0);
        cyc(1'b1, 16'hAAAA, u, 16'hCCCD, d, 1'b0, 16'h0, 1'b0);
        u = u + 16'd1; d = d - 16'd1;
        chk("R3 lane2 bad", 32'(err_flags), 32'b0100);
    endtask

    task automatic t_gap();
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 16'h5555, u + 16'd7, 16'h0, d, 1'b0, 16'h0, 1'b0);
        end
        chk("R8 gap no flag", 32'(err_flags), 0);
        chk("R8 gap missing", 32'(missing_cnt), 0);
        chk("R8 gap extra", 32'(extra_cnt), 0);
        good(1'b0, 16'h0);
        chk("R8 ramp resumes", 32'(err_flags), 0);
        chk("R8 still locked", 32'(locked), 1);
    endtask

    task automatic t_missing();
        u = u + 16'd2;
        good(1'b0, 16'h0);
        chk("R5 up skip flag", 32'(err_flags), 32'b0010);
        chk("R5 up skip count", 32'(missing_cnt), 2);
        good(1'b0, 16'h0);
        chk("R5 resync to received", 32'(err_flags), 0);
        d = d - 16'd1;
        good(1'b0, 16'h0);
        chk("R5 down skip flag", 32'(err_flags), 32'b1000);
        chk("R5 down skip count", 32'(missing_cnt), 3);
    endtask

    task automatic t_extra();
        u = u - 16'd1;
        d = d + 16'd1;
        good(1'b0, 16'h0);
        chk("R6 repeat flags", 32'(err_flags), 32'b1010);
        chk("R6 extra count", 32'(extra_cnt), 2);
        chk("R6 missing unchanged", 32'(missing_cnt), 3);
    endtask

    task automatic t_wild();
        cyc(1'b1, 16'hAAAA, u + 16'd1000, 16'hCCCC, d, 1'b0, 16'h0, 1'b0);
        chk("R7 wild flag", 32'(err_flags), 32'b0010);
        chk("R7 lock lost", 32'(locked), 0);
        chk("R7 missing unchanged", 32'(missing_cnt), 3);
        chk("R7 extra unchanged", 32'(extra_cnt), 2);
        u = 16'hFFFE; d = 16'h0001;
        cyc(1'b1, 16'h0BAD, u, 16'h0BAD, d, 1'b0, 16'h0, 1'b0);
        u = u + 16'd1; d = d - 16'd1;
        chk("R7 reseed unchecked", 32'(err_flags), 0);
        chk("R7 relocked", 32'(locked), 1);
        good(1'b0, 16'h0);
        good(1'b0, 16'h0);
        chk("R4 wrap both ramps", 32'(err_flags), 0);
        good(1'b0, 16'h0);
        chk("R4 after wrap", 32'(err_flags), 0);
    endtask

    task automatic t_sat();
        cyc(1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b1);
        chk("R10 clear missing", 32'(missing_cnt), 0);
        chk("R10 clear extra", 32'(extra_cnt), 0);
        u = u + 16'd7; d = d - 16'd7;
        good(1'b0, 16'h0);
        chk("R5 max skip both", 32'(missing_cnt), 14);
        u = u + 16'd7; d = d - 16'd7;
        good(1'b0, 16'h0);
        chk("R9 saturates", 32'(missing_cnt), 15);
        u = u + 16'd7;
        good(1'b0, 16'h0);
        chk("R9 stays at max", 32'(missing_cnt), 15);
        chk("R9 locked kept", 32'(locked), 1);
        u = u + 16'd7;
        cyc(1'b1, 16'hAAAA, u, 16'hCCCC, d, 1'b0, 16'h0, 1'b1);
        u = u + 16'd1; d = d - 16'd1;
        chk("R10 clear beats increment", 32'(missing_cnt), 0);
    endtask

    task automatic t_latency();
        logic [15:0] tgt;
        tgt = u + 16'd5;
        good(1'b1, tgt);
        chk("R12 done low after marker", 32'(lat_done), 0);
        good(1'b0, 16'h0);
        cyc(1'b0, 16'h0, tgt, 16'h0, 16'h0, 1'b0, 16'h0, 1'b0);
        cyc(1'b0, 16'h0, tgt, 16'h0, 16'h0, 1'b0, 16'h0, 1'b0);
        for (int i = 0; i < 3; i++) good(1'b0, 16'h0);
        chk("R11 not yet", 32'(lat_done), 0);
        good(1'b0, 16'h0);
        chk("R11 done with gaps", 32'(lat_done), 1);
        chk("R11 latency with gaps", 32'(lat_cycles), 7);
        tgt = u + 16'd134;
        good(1'b1, tgt);
        for (int i = 0; i < 133; i++) good(1'b0, 16'h0);
        chk("R11 long not yet", 32'(lat_done), 0);
        good(1'b0, 16'h0);
        chk("R11 loop of 134", 32'(lat_cycles), 134);
        chk("R11 long done", 32'(lat_done), 1);
        for (int i = 0; i < 5; i++) good(1'b0, 16'h0);
        chk("R12 result held", 32'(lat_cycles), 134);
        chk("R12 done held", 32'(lat_done), 1);
        good(1'b1, 16'h0000);
        chk("R12 marker drops done", 32'(lat_done), 0);
        chk("R12 value kept", 32'(lat_cycles), 134);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_seed();
        t_const();
        t_gap();
        t_missing();
        t_extra();
        t_wild();
        t_sat();
        t_latency();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule